// File: doc/BRIEF.md
# BISYNC Receive Control Character Recognizer

This block classifies every character delivered by a byte-synchronous receiver. It compares each character against a programmable table of up to eight control characters, using one compare mask shared by every entry. It also drops SYNC fill characters while the receiver holds character synchronization. For each character it picks one action:

- discard the character;
- write it and keep the buffer open;
- write it and close the buffer;
- write it, collect the block check bytes, and then close the buffer.

It also tells the receiver when to return to hunt mode.

Each table entry holds a character value and three flags: last-entry marker, block-check-expected and hunt-after-close. Scanning starts at entry 0 and stops at the first entry whose last-entry marker is set. The character strobe is registered, so every action pulse appears exactly one clock after the strobe that caused it.

Top module: `bisync_ctlchar_rx`

## Requirements
- R1: Entry i takes part in matching only if the last-entry marker (`tblEnd[i]`) is 0 for every entry from 0 through i. A character equal to an entry at or after the first set marker is written and does not close the buffer.
- R2: A `ctlMask` bit of 0 leaves that bit out of every table comparison. A bit of 1 requires an exact match. SYNC comparison always uses all 8 bits.
- R3: A match on an entry with `tblBcs`=0 gives `wrStrobe` and `closeBuf` together, with no `irqBuf`.
- R4: A match on an entry with `tblBcs`=1 gives `wrStrobe` without `closeBuf`. With `crcMode`=0 (LRC), the next character is written and closes the buffer, and `irqBuf` pulses with that close.
- R5: With `crcMode`=1 (CRC), two block check characters follow a `tblBcs`=1 match. The first is written without closing. The second is written with `closeBuf` and `irqBuf`.
- R6: Block check characters are written without being compared against the table or the SYNC register.
- R7: `enterHunt` pulses with the close of a buffer whose terminating entry has `tblHunt`=1. With `tblBcs`=1 it waits for the last block check character. With `tblHunt`=0 it stays low.
- R8: When `inHunt`=0, `syncValid`=1 and the character equals `syncChar`, `discard` pulses and nothing is written. If `inHunt`=1 or `syncValid`=0, the same character is handled as data.
- R9: The SYNC check comes before the table: a character equal to both the SYNC value and a table entry is discarded, and the buffer is not closed.
- R10: When several active entries match, the lowest-numbered entry decides the action.
- R11: A character that matches nothing is written, and the buffer stays open.
- R12: While `rstN` is low, all outputs are 0.
- R13: All outputs are single-cycle pulses in the clock after a `charValid` strobe. `discard` and `wrStrobe` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| charValid | input | 1 | One-cycle strobe: a received character is present |
| charData | input | 8 | Received character, parity bit included |
| inHunt | input | 1 | Receiver is in hunt mode |
| crcMode | input | 1 | 1: two CRC check bytes; 0: one LRC byte |
| syncValid | input | 1 | Enables SYNC discarding |
| syncChar | input | 8 | SYNC character value |
| ctlMask | input | 8 | Shared compare mask, 1 = compare bit |
| tblChar | input | 64 | Entry values, entry i in bits [8i+7:8i] |
| tblEnd | input | 8 | Last-entry marker per entry |
| tblBcs | input | 8 | Block-check-expected flag per entry |
| tblHunt | input | 8 | Hunt-after-close flag per entry |
| wrStrobe | output | 1 | Write the character to the buffer |
| discard | output | 1 | Drop the character |
| closeBuf | output | 1 | Close the current buffer |
| irqBuf | output | 1 | Interrupt after a block-check close |
| enterHunt | output | 1 | Receiver must return to hunt mode |

## Verification
The assertions assume that `charValid` lasts one cycle and is low during reset. They also assume that the configuration inputs stay fixed while a character is in flight. The bench therefore raises each strobe for a single cycle, separates strobes by idle cycles, and changes the mask, table or SYNC setting only between characters. Under those conditions every output pulse must trace back to the strobe one cycle earlier. A close always comes with a write, and an interrupt or a hunt request always comes with a close.

// File: rtl/bisync_rx_pkg.sv
package bisync_rx_pkg;
  typedef struct packed {
    logic syncHit;
    logic ctlHit;
    logic bcsFlag;
    logic huntFlag;
  } matchInfo_t;

  typedef struct packed {
    logic wr;
    logic disc;
    logic close;
    logic irq;
    logic hunt;
  } rxAction_t;
endpackage

// File: rtl/bisync_match_dp.sv
module bisync_match_dp
  import bisync_rx_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int CHAR_W      = 8
) (
  input  logic [CHAR_W-1:0]             charData,
  input  logic                          inHunt,
  input  logic                          syncValid,
  input  logic [CHAR_W-1:0]             syncChar,
  input  logic [CHAR_W-1:0]             ctlMask,
  input  logic [NUM_ENTRIES*CHAR_W-1:0] tblChar,
  input  logic [NUM_ENTRIES-1:0]        tblEnd,
  input  logic [NUM_ENTRIES-1:0]        tblBcs,
  input  logic [NUM_ENTRIES-1:0]        tblHunt,
  output matchInfo_t                    matchOut
);
  logic [NUM_ENTRIES-1:0] entryActive;
  logic [NUM_ENTRIES-1:0] entryHit;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    if (i == 0) begin : g_first
      assign entryActive[i] = ~tblEnd[i];
    end else begin : g_rest
      assign entryActive[i] = entryActive[i-1] & ~tblEnd[i];
    end
    assign entryHit[i] = entryActive[i] &
      ~|((charData ^ tblChar[i*CHAR_W +: CHAR_W]) & ctlMask);
  end

  always_comb begin
    matchOut = '0;
    matchOut.syncHit = syncValid & ~inHunt & (charData == syncChar);
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (entryHit[i]) begin
        matchOut.ctlHit   = 1'b1;
        matchOut.bcsFlag  = tblBcs[i];
        matchOut.huntFlag = tblHunt[i];
      end
    end
  end
endmodule

// File: rtl/bisync_rx_ctrl.sv
module bisync_rx_ctrl
  import bisync_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       charValid,
  input  logic       crcMode,
  input  matchInfo_t matchIn,
  output rxAction_t  actOut
);
  logic       collecting;
  logic [1:0] bcsLeft;
  logic       huntPending;
  rxAction_t  nextAct;

  always_comb begin
    nextAct = '0;
    if (charValid) begin
      if (collecting) begin
        nextAct.wr = 1'b1;
        if (bcsLeft == 2'd1) begin
          nextAct.close = 1'b1;
          nextAct.irq   = 1'b1;
          nextAct.hunt  = huntPending;
        end
      end else if (matchIn.syncHit) begin
        nextAct.disc = 1'b1;
      end else begin
        nextAct.wr = 1'b1;
        if (matchIn.ctlHit && !matchIn.bcsFlag) begin
          nextAct.close = 1'b1;
          nextAct.hunt  = matchIn.huntFlag;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actOut      <= '0;
      collecting  <= 1'b0;
      bcsLeft     <= '0;
      huntPending <= 1'b0;
    end else begin
      actOut <= nextAct;
      if (charValid) begin
        if (collecting) begin
          bcsLeft <= bcsLeft - 2'd1;
          if (bcsLeft == 2'd1) collecting <= 1'b0;
        end else if (!matchIn.syncHit && matchIn.ctlHit && matchIn.bcsFlag) begin
          collecting  <= 1'b1;
          bcsLeft     <= crcMode ? 2'd2 : 2'd1;
          huntPending <= matchIn.huntFlag;
        end
      end
    end
  end
endmodule

// File: rtl/bisync_ctlchar_rx.sv
module bisync_ctlchar_rx
  import bisync_rx_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int CHAR_W      = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          charValid,
  input  logic [CHAR_W-1:0]             charData,
  input  logic                          inHunt,
  input  logic                          crcMode,
  input  logic                          syncValid,
  input  logic [CHAR_W-1:0]             syncChar,
  input  logic [CHAR_W-1:0]             ctlMask,
  input  logic [NUM_ENTRIES*CHAR_W-1:0] tblChar,
  input  logic [NUM_ENTRIES-1:0]        tblEnd,
  input  logic [NUM_ENTRIES-1:0]        tblBcs,
  input  logic [NUM_ENTRIES-1:0]        tblHunt,
  output logic                          wrStrobe,
  output logic                          discard,
  output logic                          closeBuf,
  output logic                          irqBuf,
  output logic                          enterHunt
);
  matchInfo_t matchInfo;
  rxAction_t  action;

  bisync_match_dp #(.NUM_ENTRIES(NUM_ENTRIES), .CHAR_W(CHAR_W)) dp_i (
    .charData(charData), .inHunt(inHunt), .syncValid(syncValid),
    .syncChar(syncChar), .ctlMask(ctlMask), .tblChar(tblChar),
    .tblEnd(tblEnd), .tblBcs(tblBcs), .tblHunt(tblHunt),
    .matchOut(matchInfo)
  );

  bisync_rx_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .charValid(charValid), .crcMode(crcMode),
    .matchIn(matchInfo), .actOut(action)
  );

  assign wrStrobe  = action.wr;
  assign discard   = action.disc;
  assign closeBuf  = action.close;
  assign irqBuf    = action.irq;
  assign enterHunt = action.hunt;
endmodule

// File: rtl/bisync_ctlchar_rx_chk.sv
module bisync_ctlchar_rx_chk (
  input logic clk,
  input logic rstN,
  input logic charValid,
  input logic wrStrobe,
  input logic discard,
  input logic closeBuf,
  input logic irqBuf,
  input logic enterHunt
);
  // R13
  excl_wr_disc_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrStrobe && discard));
  // R13
  pulse_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe || discard) |-> $past(charValid));
  // R3
  close_with_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    closeBuf |-> wrStrobe);
  // R4
  irq_with_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqBuf |-> closeBuf);
  // R7
  hunt_with_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    enterHunt |-> closeBuf);
  // R12
  always @(posedge clk) begin
    if (!rstN && $past(!rstN))
      reset_quiet_chk: assert (!(wrStrobe || discard || closeBuf || irqBuf || enterHunt));
  end
endmodule

bind bisync_ctlchar_rx bisync_ctlchar_rx_chk chk_i (
  .clk(clk), .rstN(rstN), .charValid(charValid), .wrStrobe(wrStrobe),
  .discard(discard), .closeBuf(closeBuf), .irqBuf(irqBuf), .enterHunt(enterHunt)
);

// File: tb/bisync_ctlchar_rx_tb_top.sv
module bisync_ctlchar_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  // vector: {char, inHunt, crcMode, expected {wr, disc, close, irq, hunt}}
  localparam logic [14:0] VEC [NV] = '{
    {8'h41, 1'b0, 1'b0, 5'b10000},  // R11 unmatched
    {8'h32, 1'b0, 1'b0, 5'b01000},  // R8 sync discarded
    {8'h32, 1'b1, 1'b0, 5'b10000},  // R8 in hunt -> data
    {8'h10, 1'b0, 1'b0, 5'b10100},  // R3 close
    {8'h37, 1'b0, 1'b0, 5'b10101},  // R7 close + hunt
    {8'h55, 1'b0, 1'b0, 5'b10000},  // R1 end entry itself
    {8'h66, 1'b0, 1'b0, 5'b10000},  // R1 beyond end
    {8'h03, 1'b0, 1'b0, 5'b10000},  // R4 bcs expected
    {8'h32, 1'b0, 1'b0, 5'b10111},  // R6 R4 LRC byte closes, hunt deferred R7
    {8'h26, 1'b0, 1'b1, 5'b10000},  // R5 bcs, crc
    {8'h10, 1'b0, 1'b1, 5'b10000},  // R6 first crc byte not matched
    {8'h99, 1'b0, 1'b1, 5'b10110}   // R5 second crc byte closes
  };

  logic clk = 1'b0, rstN = 1'b0, charValid = 1'b0, inHunt = 1'b0, crcMode = 1'b0;
  logic syncValid = 1'b1;
  logic [7:0] charData = '0, syncChar = 8'h32, ctlMask = 8'hFF;
  logic [63:0] tblChar = {8'h00, 8'h00, 8'h66, 8'h55, 8'h37, 8'h26, 8'h10, 8'h03};
  logic [7:0] tblEnd = 8'b0001_0000, tblBcs = 8'b0010_0101, tblHunt = 8'b0010_1001;
  logic wrStrobe, discard, closeBuf, irqBuf, enterHunt;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bisync_ctlchar_rx dut_i (
    .clk(clk), .rstN(rstN), .charValid(charValid), .charData(charData),
    .inHunt(inHunt), .crcMode(crcMode), .syncValid(syncValid), .syncChar(syncChar),
    .ctlMask(ctlMask), .tblChar(tblChar), .tblEnd(tblEnd), .tblBcs(tblBcs),
    .tblHunt(tblHunt), .wrStrobe(wrStrobe), .discard(discard), .closeBuf(closeBuf),
    .irqBuf(irqBuf), .enterHunt(enterHunt)
  );

  task automatic check(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {wrStrobe, discard, closeBuf, irqBuf, enterHunt};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: outputs actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic sendChar(input logic [7:0] c, input logic h, input logic crc,
                          input logic [4:0] exp, input string req);
    @(negedge clk);
    charData = c; inHunt = h; crcMode = crc; charValid = 1'b1;
    @(negedge clk);
    charValid = 1'b0;
    check(req, exp);
    @(negedge clk);
    check("R13 pulse width", 5'b00000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset", 5'b00000);
    rstN = 1'b1;
    for (int k = 0; k < NV; k++)
      sendChar(VEC[k][14:7], VEC[k][6], VEC[k][5], VEC[k][4:0], $sformatf("vector %0d", k));
    // R8: valid bit clear -> sync char written
    syncValid = 1'b0;
    sendChar(8'h32, 1'b0, 1'b0, 5'b10000, "R8 sync invalid");
    syncValid = 1'b1;
    // R2: upper-nibble-only mask, 0x1A matches entry 1 (0x10)
    ctlMask = 8'hF0;
    sendChar(8'h1A, 1'b0, 1'b0, 5'b10100, "R2 masked match");
    // R2: SYNC compare uses all bits, 0x3F not sync; masked hits entry 3 (0x37)
    sendChar(8'h3F, 1'b0, 1'b0, 5'b10101, "R2 sync full compare");
    // R10: mask all zero, every active entry matches; entry 0 (bcs, hunt) wins
    ctlMask = 8'h00;
    sendChar(8'hEE, 1'b0, 1'b0, 5'b10000, "R10 lowest wins");
    sendChar(8'hEE, 1'b0, 1'b0, 5'b10111, "R10 bcs close of entry 0");
    // R9: sync value equal to table entry 1
    ctlMask = 8'hFF; syncChar = 8'h10;
    sendChar(8'h10, 1'b0, 1'b0, 5'b01000, "R9 sync before table");
    // R6: sync char during bcs is written
    sendChar(8'h03, 1'b0, 1'b0, 5'b10000, "R4 bcs start");
    sendChar(8'h10, 1'b0, 1'b0, 5'b10111, "R6 sync ignored in bcs");
    // R12: reset mid-collection, then outputs quiet
    sendChar(8'h03, 1'b0, 1'b1, 5'b10000, "R5 bcs start");
    rstN = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R12 reset quiet", 5'b00000);
    rstN = 1'b1;
    sendChar(8'h41, 1'b0, 1'b1, 5'b10000, "R12 collection cleared");
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL R13 watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule